// File: doc/BRIEF.md
# Pacemaker Pulse Edge Detector

This block watches a stream of signed samples taken from a fast converter that digitizes one single-ended pace channel. It looks for the steep rising or falling edges that artificial pacemaker pulses produce. Each accepted sample first passes through a four-sample moving average. The block then takes the difference between the newest smoothed value and the smoothed value from K samples earlier. If the magnitude of that difference is above a programmable threshold, a sticky detection flag is set.

Every sample is handled in the clock cycle in which it is presented. Nothing is buffered. A small controller has three states. PRIME blocks detection until the smoothing window and the longest delay line hold real data. ARMED is the only state in which a detection can happen. HOLD ignores a programmable number of further samples after a detection, so that one pulse is not counted twice.

The state transitions are:
- PRIME to ARMED, on the 11th valid sample after reset.
- ARMED to HOLD, on a detection when the holdoff count is not zero.
- ARMED stays in ARMED, on a detection when the holdoff count is zero.
- HOLD to ARMED, when the last suppressed sample has been taken.

Top module: `pace_edge_detect`

## Requirements
- R1: While reset is asserted and after it is released, `pace_flag` is 0 and the controller is in PRIME.
- R2: The smoothed value is y[n] = floor((x[n]+x[n-1]+x[n-2]+x[n-3])/4), where x[n] is the current valid sample. Samples from before reset count as zero.
- R3: The difference is d[n] = y[n] - y[n-K], with K = `span_sel` + 1, so `span_sel` 0 to 7 selects a span of 1 to 8 samples.
- R4: A valid sample in ARMED is a detection when |d[n]| > `thresh` (a strict comparison). Both polarities count. `pace_flag` reads 1 after the clock edge that accepts that sample.
- R5: The first 11 valid samples after reset never cause a detection, whatever their values.
- R6: After a detection, the next `holdoff` valid samples cannot cause a detection. With `holdoff` = 0, the next sample can cause one.
- R7: `pace_flag` stays set until a cycle with `flag_clr` = 1. If a clear and a detection fall in the same cycle, the flag stays set.
- R8: A cycle with `smp_valid` = 0 does not change the smoothing history, the delay line, the holdoff count, or the flag except through `flag_clr`.
- R9: The difference and magnitude are computed two bits wider than the input. A full-scale step from the most negative to the most positive input gives |d| = 4095 exactly, for the default 12-bit width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_valid | input | 1 | Qualifies `smp_data` for this cycle |
| smp_data | input | DW | Signed two's-complement sample |
| thresh | input | DW+2 | Unsigned magnitude threshold |
| span_sel | input | clog2(SPAN_MAX) | Differentiator span minus one |
| holdoff | input | HOLD_W | Number of samples ignored after a detection |
| flag_clr | input | 1 | One-cycle clear of the detection flag |
| pace_flag | output | 1 | Sticky detection flag |

## Verification
Every result of this block appears one clock edge after the cycle that carries its stimulus. The smoothing, differencing, comparison and flag update all finish in the cycle in which the sample is accepted.

The driver presents each sample or clear on a falling edge. It then lets one rising edge pass and queues the flag value that its independent model predicts. The monitor compares that value on the next falling edge, so every comparison lands exactly one edge after its stimulus.

Idle cycles are checked the same way, which shows that a cycle without `smp_valid` leaves the flag and the history untouched.

// File: rtl/pace_pkg.sv
package pace_pkg;
    typedef enum logic [1:0] {
        ST_PRIME = 2'd0,
        ST_ARMED = 2'd1,
        ST_HOLD  = 2'd2
    } pace_state_e;
endpackage

// File: rtl/pace_smoother.sv
module pace_smoother #(
    parameter int DW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    output logic signed [DW-1:0] smooth
);
    localparam int SW = DW + 2;

    logic signed [DW-1:0] tap_q [4];
    logic signed [SW-1:0] sum_q;
    logic signed [SW-1:0] sum_new;

    // running sum over the newest four samples
    assign sum_new = sum_q + SW'(smp_data) - SW'(tap_q[3]);
    assign smooth  = DW'(sum_new >>> 2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q <= '0;
            for (int i = 0; i < 4; i++) tap_q[i] <= '0;
        end else if (smp_valid) begin
            sum_q    <= sum_new;
            tap_q[0] <= smp_data;
            for (int i = 1; i < 4; i++) tap_q[i] <= tap_q[i-1];
        end
    end
endmodule

// File: rtl/pace_span_diff.sv
module pace_span_diff #(
    parameter int DW       = 12,
    parameter int SPAN_MAX = 8,
    localparam int EW      = DW + 2,
    localparam int SSW     = $clog2(SPAN_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smooth,
    input  logic [SSW-1:0]       span_sel,
    output logic [EW-1:0]        mag
);
    logic signed [DW-1:0] hist_q [SPAN_MAX];
    logic signed [EW-1:0] delta;

    // delay line of smoothed values: stage 0 holds the previous one
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hist_q[0] <= '0;
        else if (smp_valid) hist_q[0] <= smooth;
    end

    for (genvar g = 1; g < SPAN_MAX; g++) begin : g_dly
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)         hist_q[g] <= '0;
            else if (smp_valid) hist_q[g] <= hist_q[g-1];
        end
    end

    assign delta = EW'(smooth) - EW'(hist_q[span_sel]);
    assign mag   = delta[EW-1] ? EW'(-delta) : EW'(delta);
endmodule

// File: rtl/pace_ctrl.sv
module pace_ctrl
    import pace_pkg::*;
#(
    parameter int DW       = 12,
    parameter int SPAN_MAX = 8,
    parameter int HOLD_W   = 8,
    localparam int EW      = DW + 2,
    localparam int PRIME_N = 3 + SPAN_MAX,
    localparam int PW      = $clog2(PRIME_N),
    localparam int CW      = (HOLD_W > PW) ? HOLD_W : PW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [EW-1:0]     mag,
    input  logic [EW-1:0]     thresh,
    input  logic [HOLD_W-1:0] holdoff,
    input  logic              flag_clr,
    output logic              hit,
    output pace_state_e       state,
    output logic              pace_flag
);
    pace_state_e      state_nx;
    logic [CW-1:0]    cnt_q, cnt_nx;

    assign hit = smp_valid && (state == ST_ARMED) && (mag > thresh);

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt_q;
        unique case (state)
            ST_PRIME: if (smp_valid) begin
                if (cnt_q == CW'(PRIME_N - 1)) begin
                    state_nx = ST_ARMED;
                    cnt_nx   = '0;
                end else begin
                    cnt_nx = cnt_q + 1'b1;
                end
            end
            ST_ARMED: if (hit && (holdoff != '0)) begin
                state_nx = ST_HOLD;
                cnt_nx   = CW'(holdoff);
            end
            ST_HOLD: if (smp_valid) begin
                if (cnt_q == CW'(1)) state_nx = ST_ARMED;
                cnt_nx = cnt_q - 1'b1;
            end
            default: state_nx = ST_PRIME;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_PRIME;
            cnt_q <= '0;
        end else begin
            state <= state_nx;
            cnt_q <= cnt_nx;
        end
    end

    // output register: a detection wins over a clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pace_flag <= 1'b0;
        else if (hit)      pace_flag <= 1'b1;
        else if (flag_clr) pace_flag <= 1'b0;
    end
endmodule

// File: rtl/pace_edge_detect.sv
module pace_edge_detect
    import pace_pkg::*;
#(
    parameter int DW       = 12,
    parameter int SPAN_MAX = 8,
    parameter int HOLD_W   = 8,
    localparam int EW      = DW + 2,
    localparam int SSW     = $clog2(SPAN_MAX)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 smp_valid,
    input  logic signed [DW-1:0] smp_data,
    input  logic [EW-1:0]        thresh,
    input  logic [SSW-1:0]       span_sel,
    input  logic [HOLD_W-1:0]    holdoff,
    input  logic                 flag_clr,
    output logic                 pace_flag
);
    logic signed [DW-1:0] smooth;
    logic [EW-1:0]        mag;
    logic                 hit;
    pace_state_e          state;

    pace_smoother #(.DW(DW)) u_smooth (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smp_data(smp_data), .smooth(smooth)
    );

    pace_span_diff #(.DW(DW), .SPAN_MAX(SPAN_MAX)) u_diff (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid),
        .smooth(smooth), .span_sel(span_sel), .mag(mag)
    );

    pace_ctrl #(.DW(DW), .SPAN_MAX(SPAN_MAX), .HOLD_W(HOLD_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .mag(mag),
        .thresh(thresh), .holdoff(holdoff), .flag_clr(flag_clr),
        .hit(hit), .state(state), .pace_flag(pace_flag)
    );
endmodule

// File: rtl/pace_edge_detect_chk.sv
module pace_edge_detect_chk
    import pace_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        smp_valid,
    input logic        flag_clr,
    input logic        pace_flag,
    input logic        hit,
    input pace_state_e state
);
    // R1: the flag is low after any edge taken in reset
    assert_reset_flag_R1: assert property (@(posedge clk) !rst_n |=> !pace_flag);

    // R4: a detection shows on the flag one edge later
    assert_set_on_hit_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> pace_flag);

    // R5 / R6: outside ARMED nothing is detected
    assert_quiet_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_ARMED) |-> !hit);

    // R7: a clear without a detection drops the flag
    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !hit) |=> !pace_flag);

    // R7: without clear or detection the flag is held
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_clr && !hit) |=> (pace_flag == $past(pace_flag)));

    // R8: an idle cycle never detects
    assert_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |-> !hit);
endmodule

bind pace_edge_detect pace_edge_detect_chk u_chk (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .flag_clr(flag_clr),
    .pace_flag(pace_flag), .hit(hit), .state(state)
);

// File: tb/pace_edge_detect_tb.sv
module pace_edge_detect_tb;
    localparam int DW = 12;
    localparam int EW = DW + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_valid = 1'b0;
    logic signed [DW-1:0] smp_data = '0;
    logic [EW-1:0] thresh = '1;
    logic [2:0] span_sel = '0;
    logic [7:0] holdoff = '0;
    logic flag_clr = 1'b0;
    logic pace_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    pace_edge_detect u_dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .thresh(thresh), .span_sel(span_sel), .holdoff(holdoff),
        .flag_clr(flag_clr), .pace_flag(pace_flag)
    );

    // ---------------- reference model from the requirements
    int xh[4];
    int yh[8];
    int m_st  = 0;   // 0 priming, 1 armed, 2 holding
    int m_cnt = 0;
    bit m_flag = 0;

    task automatic model(input bit v, input int x, input bit clr);
        bit h = 0;
        if (v) begin
            int y, d, mg;
            y  = (x + xh[0] + xh[1] + xh[2]) >>> 2;   // R2 floor average
            d  = y - yh[span_sel];                    // R3 span K = sel+1
            mg = (d < 0) ? -d : d;
            case (m_st)
                0: begin
                    if (m_cnt == 10) begin m_st = 1; m_cnt = 0; end
                    else m_cnt++;
                end
                1: if (mg > int'(thresh)) begin
                    h = 1;
                    if (holdoff != 0) begin m_st = 2; m_cnt = holdoff; end
                end
                default: begin
                    if (m_cnt == 1) m_st = 1;
                    m_cnt--;
                end
            endcase
            for (int i = 3; i > 0; i--) xh[i] = xh[i-1];
            xh[0] = x;
            for (int i = 7; i > 0; i--) yh[i] = yh[i-1];
            yh[0] = y;
        end
        if (h) m_flag = 1;
        else if (clr) m_flag = 0;
    endtask

    // ---------------- scoreboard
    typedef struct { bit exp; string tag; } item_t;
    item_t q[$];

    task automatic send(input bit v, input int x, input bit clr, input string tag);
        item_t it;
        @(negedge clk);
        smp_valid = v;
        smp_data  = DW'(x);
        flag_clr  = clr;
        model(v, x, clr);
        @(posedge clk);
        #1;
        it.exp = m_flag;
        it.tag = tag;
        q.push_back(it);
    endtask

    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (pace_flag !== it.exp) begin
                fails++;
                $display("FAIL %s: pace_flag actual %0b expected %0b", it.tag, pace_flag, it.exp);
            end
        end
    end

    task automatic flat(input int v, input int n, input bit clr, input string tag);
        for (int i = 0; i < n; i++) send(1, v, clr, tag);
    endtask

    task automatic ramp(input int s, input int st, input int n, input bit clr, input string tag);
        for (int i = 0; i < n; i++) send(1, s + i * st, clr, tag);
    endtask

    task automatic clear(input string tag);
        send(0, 0, 1, tag);
    endtask

    // ---------------- stimulus
    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (pace_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1: flag in reset actual %0b expected 0", pace_flag);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (pace_flag !== 1'b0) begin
            fails++;
            $display("FAIL R1: flag after reset actual %0b expected 0", pace_flag);
        end

        // R5: wild priming samples with zero threshold must not trigger
        thresh = '0;
        for (int i = 0; i < 11; i++) send(1, (i % 2) ? 2000 : -2000, 0, "R5 priming");
        thresh = '1;
        flat(0, 12, 0, "R5 settle");

        // R4 / R2 / R3: rising step, then falling step
        thresh = 100; span_sel = 3; holdoff = 0;
        flat(0, 6, 0, "R4 flat");
        flat(400, 6, 0, "R4 rising step");
        clear("R7 clear");
        flat(-400, 8, 0, "R4 falling step");
        clear("R7 clear");

        // R3: slope 30 seen by span 1 vs span 8
        span_sel = 0;
        ramp(-600, 30, 20, 0, "R3 span 1 slow ramp");
        clear("R7 clear");
        span_sel = 7;
        ramp(0, 30, 16, 0, "R3 span 8 slow ramp");
        clear("R7 clear");

        // R4: equality boundary, |d| settles at exactly 100
        span_sel = 3; thresh = 100;
        flat(-600, 8, 0, "R4 settle");
        ramp(-600, 25, 20, 0, "R4 equal threshold");
        clear("R7 clear");
        thresh = 99;
        ramp(-100, 25, 12, 0, "R4 threshold minus one");
        clear("R7 clear");

        // R6 / R7: steep ramp with clear on every sample exposes each detection
        thresh = 100; holdoff = 5;
        ramp(-900, 60, 20, 1, "R6 holdoff 5");
        holdoff = 0;
        ramp(300, -60, 12, 1, "R6 holdoff 0");

        // R8: idle cycles with junk data and no clear keep flag and history
        flat(0, 1, 0, "R8 prep");
        holdoff = 0; thresh = 50;
        flat(300, 4, 0, "R8 set flag");
        for (int i = 0; i < 4; i++) send(0, (i % 2) ? 2047 : -2048, 0, "R8 idle hold");
        clear("R7 clear");
        flat(300, 6, 0, "R8 history intact");

        // R9: full-scale step
        span_sel = 3; thresh = 4000;
        flat(-2048, 12, 0, "R9 low rail");
        clear("R7 clear");
        flat(2047, 8, 0, "R9 full step over 4000");
        clear("R7 clear");
        thresh = 4095;
        flat(-2048, 12, 0, "R9 low rail");
        flat(2047, 8, 0, "R9 full step at 4095");

        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule